// File: doc/BRIEF.md
# Dual-Polynomial Side-Stream Scrambler Register

This block is the 33-bit shift register at the heart of a gigabit twisted-pair transmitter's side-stream scrambler. Each symbol period it takes one step. A role input selects the feedback polynomial: 1 + x^13 + x^33 when the port is the timing master, and 1 + x^20 + x^33 when it is the slave. The full register is driven out in parallel on every cycle so that downstream word generators can pick any taps they need.

Software or start-up logic seeds the register through a synchronous load port. A seed of all zeros would lock the register at zero for good, so the block substitutes a fixed nonzero default in that case. The step enable is pulsed once per 125 MHz symbol. The role may be changed while the register runs: the state is kept, and the next step uses the new polynomial.

Top module: `sidestream_lfsr`

## Requirements
- R1: In master role (`role_slave`=0), a step sets new bit 0 to state[12] XOR state[32], the taps of 1 + x^13 + x^33.
- R2: In slave role (`role_slave`=1), a step sets new bit 0 to state[19] XOR state[32], the taps of 1 + x^20 + x^33.
- R3: On a step, bits 31..0 move up to bits 32..1, and all 33 bits appear on `state` every cycle.
- R4: When `load` is high with a nonzero `seed`, `state` equals `seed` after that clock edge.
- R5: When `load` is high with an all-zero `seed`, `state` becomes the default 33'h1_2345_6789.
- R6: With `load` and `step` both low, `state` keeps its value.
- R7: A change of `role_slave` clears nothing; the step right after the change uses the new polynomial.
- R8: After reset, `state` is the default 33'h1_2345_6789.
- R9: From a nonzero seed, `state` never becomes all zeros in 10,000 steps.
- R10: When `load` and `step` are high together, the load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_slave | input | 1 | 0 selects the master polynomial, 1 the slave polynomial |
| load | input | 1 | Synchronous seed load |
| seed | input | 33 | Seed value for a load |
| step | input | 1 | Advance by one symbol |
| state | output | 33 | Whole register contents |

## Verification
Because the whole register is visible on `state`, a wrong feedback tap or a lost bit shows up one cycle after the step that caused it, in bit 0 or in the shifted bits. The bench runs a bit-serial model of the register next to the design. It compares every cycle across runs in both roles, role switches mid-run, holds, loads, and loads of zero, so any difference is reported in the cycle it occurs. A state that collapses to zero would be visible at once and stay visible, and a 10,000-step run checks that this does not happen.

// File: rtl/sidestream_lfsr.sv
module sidestream_lfsr #(
  parameter int W = 33,
  parameter int TAP_M = 13,
  parameter int TAP_S = 20,
  parameter logic [W-1:0] DFLT = 33'h1_2345_6789
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         role_slave,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam int IM = TAP_M - 1;
  localparam int IS = TAP_S - 1;

  logic [W-1:0] st_q;
  logic [W-1:0] load_val;
  logic         fb;

  assign fb       = st_q[W-1] ^ (role_slave ? st_q[IS] : st_q[IM]);
  assign load_val = (seed == '0) ? DFLT : seed;
  assign state    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= DFLT;
    else if (load) st_q <= load_val;
    else if (step) st_q <= {st_q[W-2:0], fb};
  end

  p_master_fb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !role_slave) |=> state[0] == ($past(state[IM]) ^ $past(state[W-1])));
  p_slave_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && role_slave) |=> state[0] == ($past(state[IS]) ^ $past(state[W-1])));
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> state[W-1:1] == $past(state[W-2:0]));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> state == $past(seed));
  p_zero_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> state == DFLT);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state));
  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: tb/tb_sidestream_lfsr.sv
`timescale 1ns/1ps
module tb_sidestream_lfsr;
  localparam logic [32:0] DEF = 33'h1_2345_6789;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        role_slave = 1'b0;
  logic        load = 1'b0;
  logic [32:0] seed = '0;
  logic        step = 1'b0;
  logic [32:0] state;

  int checks = 0;
  int errors = 0;
  bit zero_seen = 1'b0;
  bit track_zero = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [32:0] model;

  sidestream_lfsr dut (
    .clk(clk), .rst_n(rst_n), .role_slave(role_slave), .load(load),
    .seed(seed), .step(step), .state(state)
  );

  always #4 clk = ~clk;

  function automatic logic [32:0] ref_step(input logic [32:0] s, input logic slv);
    logic [32:0] r;
    logic nb;
    nb = s[32] ^ (slv ? s[19] : s[12]);
    r = s;
    for (int i = 32; i > 0; i--) r[i] = r[i-1];
    r[0] = nb;
    return r;
  endfunction

  task automatic drive(input logic ld, input logic [32:0] sd, input logic st,
                       input logic slv, input string tag);
    @(negedge clk);
    load = ld; seed = sd; step = st; role_slave = slv;
    if (ld) model = (sd == '0) ? DEF : sd;
    else if (st) model = ref_step(model, slv);
    @(posedge clk);
    #1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (state !== e) begin
        errors++;
        $display("FAIL %s state=%h expected=%h", t, state, e);
      end
    end
    if (track_zero && state == '0) zero_seen = 1'b1;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog state=%h expected=finish", state);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model = DEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (state !== DEF) begin
      errors++;
      $display("FAIL R8 state=%h expected=%h", state, DEF);
    end

    for (int i = 0; i < 60; i++) drive(0, '0, 1, 0, "R1 R3 master run");
    for (int i = 0; i < 5; i++)  drive(0, 33'h0_DEAD_BEEF, 0, 0, "R6 hold");
    drive(1, 33'h0_0000_0001, 0, 1, "R4 load one");
    for (int i = 0; i < 60; i++) drive(0, '0, 1, 1, "R2 R3 slave run");
    drive(1, 33'h1_0000_0000, 0, 0, "R4 load msb");
    for (int i = 0; i < 40; i++) drive(0, '0, 1, 0, "R1 msb master");
    drive(1, '0, 0, 0, "R5 zero seed");
    drive(1, '0, 1, 1, "R5 R10 zero seed with step");
    drive(1, 33'h0_ABCD_0123, 1, 0, "R10 load beats step");
    for (int i = 0; i < 5; i++)  drive(0, '0, 0, 1, "R6 R7 hold across role change");
    for (int i = 0; i < 300; i++) drive(0, '0, 1, ((i / 7) % 2) == 1, "R7 role toggling");
    for (int i = 0; i < 50; i++) drive(0, '0, (i % 3) != 0, 1, "R6 gapped slave");

    drive(1, 33'h0_0000_0001, 0, 0, "R4 seed for long run");
    track_zero = 1'b1;
    for (int i = 0; i < 10000; i++) drive(0, '0, 1, 0, "R9 long run");
    repeat (3) @(negedge clk);
    track_zero = 1'b0;
    checks++;
    if (zero_seen) begin
      errors++;
      $display("FAIL R9 zero_seen=1 expected=0");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule